// File: doc/BRIEF.md
# Dual-mode table-driven lag correlator and level histogram

This block turns a stream of 16-sample packets of 4-bit sampler codes into 16 running sums. One datapath does both jobs. In lag mode, channel k adds up table values for every pair of samples that are k positions apart inside a packet. With a product table loaded, the sums form a 16-lag autocorrelation, and channel 0 holds the signal power. In level mode, channel k pairs its own index with each sample. With an equality table loaded, each channel counts how often its level occurs.

The host writes the 256-entry signed table through a simple write port. It then pulses a start input, which latches the mode and a packet count and clears all sums. Packets enter through a valid/ready handshake. Each accepted packet takes 16 table-lookup cycles, then one cycle to drain the pipeline. When the programmed number of packets has been summed, a done flag rises. The sums then stay frozen and can be read one channel at a time through a registered readout port. Nonlinear correction and spectral transforms belong to host software.

Top module: `lagtab_accum`

## Requirements
- R1: After reset, done and pkt_ready are 0 and rd_data is 0.
- R2: A table entry written with tbl_we (address {a,b}, a in bits 7:4, b in bits 3:0; value a signed 8-bit number) is used by every channel in all later packets, and rewriting it changes later results.
- R3: In lag mode (mode_sel=0 at start), sample i of a packet is pkt_data[4i+3:4i]. Per packet, channel k adds table[{x[i], x[i+k]}] for i = 0 .. 15-k.
- R4: With a table of code products loaded, lag-mode channel 0 holds the sum of table[{x[i],x[i]}] over every sample, which is the power term.
- R5: In level mode (mode_sel=1 at start), channel k adds table[{k, x[i]}] for all 16 samples i of each packet. With an equality table loaded, each channel holds the count of its level.
- R6: done rises once exactly `target` packets have been summed. While done is high, pkt_ready stays 0, offered packets are refused, and the sums do not change.
- R7: A start pulse clears all sums, the packet counter and done, and latches mode and target. A target of 0 sets done right after start, with all sums at 0.
- R8: Each sum is a signed AW-bit value. An addition that would pass the largest or smallest value clamps to that value instead of wrapping.
- R9: rd_data shows the sum of channel rd_idx one clock after rd_idx is applied.
- R10: A packet is taken only on a clock where pkt_valid and pkt_ready are both 1. pkt_ready is 0 on the cycle after a transfer and stays 0 while that packet is processed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tbl_we | input | 1 | Table write strobe |
| tbl_addr | input | 2*SW | Table entry address {a,b} |
| tbl_data | input | PW | Signed table entry value |
| start | input | 1 | Clear sums and begin a new run |
| mode_sel | input | 1 | 0 = lag mode, 1 = level mode (sampled on start) |
| target | input | CW | Packets to sum (sampled on start) |
| pkt_valid | input | 1 | Packet offered |
| pkt_data | input | NLAG*SW | 16 sample codes, sample i at bits 4i+3:4i |
| pkt_ready | output | 1 | Block can accept a packet |
| done | output | 1 | Run complete, sums frozen |
| rd_idx | input | SW | Channel selected for readout |
| rd_data | output | AW | Registered sum of the selected channel |

## Verification
The assertions assume that start is not pulsed during the same cycles as table writes used by a packet in flight, and that pkt_data holds steady only in the transfer cycle, since the block captures it there. The no-wrap check also assumes the table holds real signed entries, so a step's sign is the sign of bit 7. The bench writes the table only between runs, pulses start only while idle or after done, and offers packets in single transfers. A second copy with 12-bit sums lets the clamp be reached with a handful of packets.

// File: rtl/lagtab_pkg.sv
package lagtab_pkg;
  typedef enum logic {
    MODE_LAGS   = 1'b0,
    MODE_LEVELS = 1'b1
  } mode_e;
endpackage

// File: rtl/lagtab_table.sv
// One copy of the product/match table: one write port, one registered read port.
module lagtab_table #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/lagtab_chan.sv
// Saturating signed accumulator for one channel.
module lagtab_chan #(
  parameter int PW = 8,
  parameter int AW = 40
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          step,
  input  logic [PW-1:0] term,
  output logic [AW-1:0] acc
);
  localparam logic [AW-1:0] MAXV = {1'b0, {(AW-1){1'b1}}};
  localparam logic [AW-1:0] MINV = {1'b1, {(AW-1){1'b0}}};

  logic [AW:0] sum;
  logic        ovf;

  always_comb begin
    sum = {acc[AW-1], acc} + {{(AW+1-PW){term[PW-1]}}, term};
    ovf = sum[AW] ^ sum[AW-1];
  end

  always_ff @(posedge clk) begin
    if (rst || clr)  acc <= '0;
    else if (step)   acc <= ovf ? (sum[AW] ? MINV : MAXV) : sum[AW-1:0];
  end

  // R8: adding a term of the same sign never flips the sign of the sum
  assert_no_wrap_R8: assert property (@(posedge clk) disable iff (rst)
    (step && !clr && (acc[AW-1] == term[PW-1])) |=> (acc[AW-1] == $past(acc[AW-1])));

  // R6: without a step or clear the sum holds
  assert_hold_idle_R6: assert property (@(posedge clk) disable iff (rst)
    (!step && !clr) |=> $stable(acc));
endmodule

// File: rtl/lagtab_ctrl.sv
// Run control: handshake, per-packet term sequencing, packet counting.
module lagtab_ctrl #(
  parameter int NLAG = 16,
  parameter int CW   = 32,
  localparam int TW  = $clog2(NLAG)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [CW-1:0] target,
  input  logic          pkt_valid,
  output logic          pkt_ready,
  output logic          load,
  output logic          issue,
  output logic [TW-1:0] term,
  output logic          done
);
  localparam logic [TW-1:0] LAST = TW'(NLAG - 1);

  logic          running;
  logic          s1_vld;
  logic          s1_last;
  logic [CW-1:0] cnt;
  logic [CW-1:0] tgt;

  assign pkt_ready = running && !issue && !s1_vld && !done;
  assign load      = pkt_ready && pkt_valid;

  always_ff @(posedge clk) begin
    if (rst) begin
      running <= 1'b0;
      issue   <= 1'b0;
      term    <= '0;
      s1_vld  <= 1'b0;
      s1_last <= 1'b0;
      cnt     <= '0;
      tgt     <= '0;
      done    <= 1'b0;
    end else if (start) begin
      running <= 1'b1;
      issue   <= 1'b0;
      term    <= '0;
      s1_vld  <= 1'b0;
      s1_last <= 1'b0;
      cnt     <= '0;
      tgt     <= target;
      done    <= (target == '0);
    end else begin
      s1_vld  <= issue;
      s1_last <= issue && (term == LAST);
      if (load) begin
        issue <= 1'b1;
        term  <= '0;
      end else if (issue) begin
        term <= term + 1'b1;
        if (term == LAST) issue <= 1'b0;
      end
      if (s1_last) begin
        cnt <= cnt + 1'b1;
        if ((cnt + 1'b1) == tgt) done <= 1'b1;
      end
    end
  end

  assert_ready_low_done_R6: assert property (@(posedge clk) disable iff (rst)
    done |-> !pkt_ready);

  assert_count_bound_R6: assert property (@(posedge clk) disable iff (rst)
    cnt <= tgt);

  assert_start_clears_R7: assert property (@(posedge clk) disable iff (rst)
    start |=> (cnt == '0) && !issue && !s1_vld);

  assert_done_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> done);

  assert_busy_after_take_R10: assert property (@(posedge clk) disable iff (rst)
    (load && !start) |=> (issue && !pkt_ready));
endmodule

// File: rtl/lagtab_accum.sv
module lagtab_accum #(
  parameter int SW  = 4,
  parameter int PW  = 8,
  parameter int AW  = 40,
  parameter int CW  = 32,
  localparam int NLAG = 1 << SW,
  localparam int TAW  = 2 * SW
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               tbl_we,
  input  logic [TAW-1:0]     tbl_addr,
  input  logic [PW-1:0]      tbl_data,
  input  logic               start,
  input  logic               mode_sel,
  input  logic [CW-1:0]      target,
  input  logic               pkt_valid,
  input  logic [NLAG*SW-1:0] pkt_data,
  output logic               pkt_ready,
  output logic               done,
  input  logic [SW-1:0]      rd_idx,
  output logic [AW-1:0]      rd_data
);
  import lagtab_pkg::*;

  mode_e              mode_q;
  logic [NLAG*SW-1:0] pkt_q;
  logic               load;
  logic               issue;
  logic [SW-1:0]      term;
  logic [SW-1:0]      lead;
  logic [AW-1:0]      acc [NLAG];

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= MODE_LAGS;
      pkt_q  <= '0;
    end else begin
      if (start) mode_q <= mode_e'(mode_sel);
      if (load)  pkt_q  <= pkt_data;
    end
  end

  lagtab_ctrl #(.NLAG(NLAG), .CW(CW)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .target   (target),
    .pkt_valid(pkt_valid),
    .pkt_ready(pkt_ready),
    .load     (load),
    .issue    (issue),
    .term     (term),
    .done     (done)
  );

  assign lead = pkt_q[term*SW +: SW];

  for (genvar k = 0; k < NLAG; k++) begin : g_chan
    logic [SW-1:0]  far_idx;
    logic [SW-1:0]  far;
    logic           in_win;
    logic [TAW-1:0] raddr;
    logic [PW-1:0]  rdata;
    logic           use_q;

    always_comb begin
      far_idx = term + SW'(k);
      far     = pkt_q[far_idx*SW +: SW];
      in_win  = (int'(term) + k) < NLAG;
      raddr   = (mode_q == MODE_LEVELS) ? {SW'(k), lead} : {lead, far};
    end

    always_ff @(posedge clk) begin
      if (rst) use_q <= 1'b0;
      else     use_q <= issue && !start && ((mode_q == MODE_LEVELS) || in_win);
    end

    lagtab_table #(.AW(TAW), .DW(PW)) u_tbl (
      .clk  (clk),
      .we   (tbl_we),
      .waddr(tbl_addr),
      .wdata(tbl_data),
      .raddr(raddr),
      .rdata(rdata)
    );

    lagtab_chan #(.PW(PW), .AW(AW)) u_acc (
      .clk (clk),
      .rst (rst),
      .clr (start),
      .step(use_q),
      .term(rdata),
      .acc (acc[k])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= acc[rd_idx];
  end

  // R10: nothing is taken while the block is not ready
  assert_take_only_ready_R10: assert property (@(posedge clk) disable iff (rst)
    (pkt_valid && !pkt_ready && !start) |=> $stable(pkt_q));
endmodule

// File: tb/lagtab_accum_bench.sv
module lagtab_accum_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tbl_we = 1'b0;
  logic [7:0]  tbl_addr = '0;
  logic [7:0]  tbl_data = '0;
  logic        start = 1'b0;
  logic        mode_sel = 1'b0;
  logic [31:0] target = '0;
  logic        pkt_valid = 1'b0;
  logic [63:0] pkt_data = '0;
  logic [3:0]  rd_idx = '0;
  logic        pkt_ready, done, ready_s, done_s;
  logic [39:0] rd_data;
  logic [11:0] rd_data_s;

  int     tbl [256];
  longint eb [16];
  longint es [16];
  logic   mode_b;
  int     nchecks = 0;
  int     nfails  = 0;

  always #2 clk = ~clk;

  lagtab_accum u_lagtab_accum (
    .clk(clk), .rst(rst), .tbl_we(tbl_we), .tbl_addr(tbl_addr), .tbl_data(tbl_data),
    .start(start), .mode_sel(mode_sel), .target(target), .pkt_valid(pkt_valid),
    .pkt_data(pkt_data), .pkt_ready(pkt_ready), .done(done), .rd_idx(rd_idx),
    .rd_data(rd_data));

  lagtab_accum #(.AW(12)) u_lagtab_accum_sat (
    .clk(clk), .rst(rst), .tbl_we(tbl_we), .tbl_addr(tbl_addr), .tbl_data(tbl_data),
    .start(start), .mode_sel(mode_sel), .target(target), .pkt_valid(pkt_valid),
    .pkt_data(pkt_data), .pkt_ready(ready_s), .done(done_s), .rd_idx(rd_idx),
    .rd_data(rd_data_s));

  task automatic chk(string req, longint act, longint exp);
    nchecks++;
    if (act != exp) begin
      nfails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic longint clampw(longint v, int w);
    longint hi = (longint'(1) <<< (w - 1)) - 1;
    longint lo = -(longint'(1) <<< (w - 1));
    return (v > hi) ? hi : ((v < lo) ? lo : v);
  endfunction

  function automatic logic [63:0] mkpkt(int s);
    logic [63:0] d;
    for (int i = 0; i < 16; i++) d[4*i +: 4] = 4'(i * 7 + s * 5 + ((i * i * s) >> 1));
    return d;
  endfunction

  task automatic wr_tbl(int a, int v);
    @(negedge clk);
    tbl_we = 1'b1; tbl_addr = 8'(a); tbl_data = 8'(v);
    tbl[a] = v;
    @(negedge clk);
    tbl_we = 1'b0;
  endtask

  task automatic load_prod();
    for (int a = 0; a < 16; a++)
      for (int b = 0; b < 16; b++) wr_tbl(a * 16 + b, ((2 * a - 15) * (2 * b - 15)) / 2);
  endtask

  task automatic load_match();
    for (int a = 0; a < 256; a++) wr_tbl(a, ((a >> 4) == (a & 15)) ? 1 : 0);
  endtask

  task automatic load_const(int v);
    for (int a = 0; a < 256; a++) wr_tbl(a, v);
  endtask

  task automatic run_start(int tgt, logic md);
    @(negedge clk);
    start = 1'b1; target = tgt; mode_sel = md; mode_b = md;
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k < 16; k++) begin eb[k] = 0; es[k] = 0; end
  endtask

  task automatic send(logic [63:0] d);
    int t;
    @(negedge clk);
    pkt_valid = 1'b1; pkt_data = d;
    while (!pkt_ready) @(negedge clk);
    @(negedge clk);
    pkt_valid = 1'b0;
    chk("R10 ready after take", longint'(pkt_ready), 0);
    for (int k = 0; k < 16; k++)
      for (int i = 0; i < 16; i++) begin
        if (mode_b) t = tbl[k * 16 + int'(d[4*i +: 4])];
        else if (i + k < 16) t = tbl[int'(d[4*i +: 4]) * 16 + int'(d[4*(i+k) +: 4])];
        else t = 0;
        eb[k] = clampw(eb[k] + t, 40);
        es[k] = clampw(es[k] + t, 12);
      end
  endtask

  task automatic wait_done(string req);
    int n = 0;
    while (!done && n < 400) begin @(negedge clk); n++; end
    chk(req, longint'(done), 1);
  endtask

  task automatic rd_chk(string req);
    for (int k = 0; k < 16; k++) begin
      @(negedge clk); rd_idx = 4'(k);
      @(negedge clk);
      chk(req, longint'($signed(rd_data)), eb[k]);
      chk(req, longint'($signed(rd_data_s)), es[k]);
    end
  endtask

  task automatic t_reset();
    chk("R1 done", longint'(done), 0);
    chk("R1 ready", longint'(pkt_ready), 0);
    chk("R1 rd_data", longint'(rd_data), 0);
  endtask

  task automatic t_tbl_update();
    load_const(0);
    wr_tbl(0, 5);
    run_start(1, 1'b0); send('0); wait_done("R2 done");
    rd_chk("R2 entry 5");
    wr_tbl(0, -3);
    run_start(1, 1'b0); send('0); wait_done("R2 done");
    rd_chk("R2 entry -3");
  endtask

  task automatic t_corr();
    load_prod();
    run_start(3, 1'b0);
    for (int p = 1; p <= 3; p++) send(mkpkt(p));
    wait_done("R6 done after 3");
    rd_chk("R3 lag sums");
    @(negedge clk); rd_idx = 4'd0;
    @(negedge clk);
    chk("R4 lag0 power", longint'($signed(rd_data)), eb[0]);
    chk("R4 lag0 positive", longint'($signed(rd_data) > 0), 1);
  endtask

  task automatic t_ignore();
    int bad = 0;
    @(negedge clk); pkt_valid = 1'b1; pkt_data = mkpkt(9);
    for (int c = 0; c < 20; c++) begin
      @(negedge clk);
      if (pkt_ready) bad++;
    end
    pkt_valid = 1'b0;
    chk("R6 ready held low", bad, 0);
    rd_chk("R6 frozen");
  endtask

  task automatic t_restart();
    run_start(2, 1'b0);
    chk("R7 done cleared", longint'(done), 0);
    rd_chk("R7 cleared");
    send(mkpkt(4)); send(mkpkt(5));
    wait_done("R7 done");
    rd_chk("R7 rerun");
    run_start(0, 1'b0);
    chk("R7 zero target", longint'(done), 1);
    rd_chk("R7 zero sums");
  endtask

  task automatic t_hist();
    longint tot = 0;
    load_match();
    run_start(4, 1'b1);
    for (int p = 6; p <= 9; p++) send(mkpkt(p));
    wait_done("R5 done");
    rd_chk("R5 level counts");
    for (int k = 0; k < 16; k++) begin
      @(negedge clk); rd_idx = 4'(k);
      @(negedge clk); tot += longint'($signed(rd_data));
    end
    chk("R5 total count", tot, 64);
  endtask

  task automatic t_sat();
    load_const(127);
    run_start(2, 1'b0); send(mkpkt(1)); send(mkpkt(2)); wait_done("R8 done");
    rd_chk("R8 clamp high");
    @(negedge clk); rd_idx = 4'd0;
    @(negedge clk); chk("R8 max", longint'($signed(rd_data_s)), 2047);
    load_const(-128);
    run_start(2, 1'b0); send(mkpkt(3)); send(mkpkt(4)); wait_done("R8 done");
    rd_chk("R8 clamp low");
    @(negedge clk); rd_idx = 4'd1;
    @(negedge clk); chk("R8 min", longint'($signed(rd_data_s)), -2048);
  endtask

  task automatic t_readlat();
    @(negedge clk); rd_idx = 4'd0;
    @(negedge clk); rd_idx = 4'd15;
    chk("R9 before edge", longint'($signed(rd_data)), eb[0]);
    @(negedge clk);
    chk("R9 one cycle", longint'($signed(rd_data)), eb[15]);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_tbl_update();
    t_corr();
    t_ignore();
    t_readlat();
    t_restart();
    t_hist();
    t_sat();
    $display("End of test - %0d assertions evaluated, %0d failures", nchecks, nfails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nchecks++; nfails++;
    $display("FAIL R6 watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nchecks, nfails);
    $finish;
  end
endmodule